// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block tracks one address reservation for each hardware context. A load-locked request records its block address and marks that context as holding a reservation. A store-conditional from a context succeeds only while that context still holds a reservation on the same 16-byte block. The block returns a result code and tells the memory whether the store may go ahead. Successful conditional stores and plain stores from any context drop every reservation on the block they write, so a competing write always breaks a pending sequence.

Each context also has a counter of consecutive conditional-store failures. Each time that count reaches a multiple of a configurable period, the block raises a one-cycle warning that carries the context number and the count, so that a stuck spin loop can be seen. Responses are combinational on the request cycle. Reservation and counter state update on the next clock edge. Requests with a context number at or above the context count are ignored.

Top module: `llsc_monitor`

## Requirements
- R1: A locked load (`req_store`=0, `req_locked`=1) stores the block address `req_addr[ADDR_W-1:4]` for the issuing context and sets that context's reservation flag. Other contexts are unchanged.
- R2: Block matching ignores address bits [3:0]. Addresses that differ only in those bits match, and addresses in different 16-byte blocks do not.
- R3: A cacheable conditional store (`req_store`=1, `req_locked`=1, `req_uncached`=0) drives `rsp_result` = {1'b0, own flag} and `rsp_dest_we`=1. It succeeds (`rsp_write_go`=1) only if the flag is set and the block matches. Otherwise `rsp_write_go`=0.
- R4: A failing conditional store clears its own context's flag and no other context's flag.
- R5: An uncached conditional store (`req_uncached`=1) returns `rsp_result`=2, `rsp_dest_we`=0 and `rsp_write_go`=1.
- R6: A successful conditional store, an uncached conditional store, or a plain store (`req_store`=1, `req_locked`=0) clears the flag of every context, including the issuer, whose reserved block equals the store's block. Other flags are kept.
- R7: A plain load, an idle cycle, or a request with an out-of-range context gives `rsp_result`=0, `rsp_write_go`=0 and `rsp_dest_we`=0, and changes no reservation.
- R8: A failing conditional store increments the issuing context's consecutive-failure count. A successful or uncached conditional store resets that count to 0.
- R9: When a failure brings a context's count to a nonzero multiple of `WARN_PERIOD`, `warn_valid` is high for exactly the next cycle, with `warn_ctx` set to that context and `warn_count` set to the new count.
- R10: Reset clears every reservation flag and every failure count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ctx | input | CTX_W | Issuing context number |
| req_addr | input | ADDR_W | Physical byte address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_locked | input | 1 | Locked load or conditional store |
| req_uncached | input | 1 | Access is uncacheable |
| rsp_result | output | 2 | Conditional store result code |
| rsp_write_go | output | 1 | Memory write may proceed |
| rsp_dest_we | output | 1 | Result goes to the destination register |
| warn_valid | output | 1 | Failure-period warning pulse |
| warn_ctx | output | CTX_W | Context that raised the warning |
| warn_count | output | CNT_W | Consecutive failure count at the warning |

## Verification
On every cycle, the assertions check the slot-level effects. A locked load takes the block, a matching snoop or a failure drops the flag, failures increment the count, and success or an uncached store clears it. They also check that at most one context fires a warning at a time, and that a granted conditional write always reports result 1. Other properties span several requests and are shown only by the bench's scenarios. These are: a reservation survives foreign traffic to other blocks, a cross-context store breaks a pending pair, the low address bits are ignored in matching, and warnings fall exactly at multiples of the period.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;

    typedef enum logic [2:0] {
        RQ_NONE,
        RQ_LOAD,
        RQ_LL,
        RQ_STORE,
        RQ_SC,
        RQ_SC_UC
    } rq_kind_e;

    localparam logic [1:0] RES_FAIL  = 2'd0;
    localparam logic [1:0] RES_OK    = 2'd1;
    localparam logic [1:0] RES_UNCAC = 2'd2;

endpackage

// File: rtl/llsc_req_decode.sv
`timescale 1ns/1ps
module llsc_req_decode
    import llsc_pkg::*;
#(
    parameter int NCTX  = 4,
    parameter int CTX_W = 2
) (
    input  logic             valid_i,
    input  logic [CTX_W-1:0] ctx_i,
    input  logic             store_i,
    input  logic             locked_i,
    input  logic             uncached_i,
    output rq_kind_e         kind_o
);

    logic ctx_ok;

    always_comb begin
        ctx_ok = (32'(ctx_i) < NCTX);
        kind_o = RQ_NONE;
        if (valid_i && ctx_ok) begin
            case ({store_i, locked_i})
                2'b00:   kind_o = RQ_LOAD;
                2'b01:   kind_o = RQ_LL;
                2'b10:   kind_o = RQ_STORE;
                default: kind_o = uncached_i ? RQ_SC_UC : RQ_SC;
            endcase
        end
    end

endmodule

// File: rtl/llsc_slot.sv
`timescale 1ns/1ps
module llsc_slot #(
    parameter int BLK_W       = 12,
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic             snoop_i,
    input  logic             fail_i,
    input  logic             clr_cnt_i,
    output logic             flag_o,
    output logic [BLK_W-1:0] blk_o,
    output logic             fire_o,
    output logic [CNT_W-1:0] cnt_next_o
);

    localparam int PH_W = $clog2(WARN_PERIOD + 1);

    typedef struct packed {
        logic             flag;
        logic [BLK_W-1:0] blk;
        logic [CNT_W-1:0] cnt;
        logic [PH_W-1:0]  ph;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        fire_o = 1'b0;
        // a clearing store is applied before a new reservation
        if (snoop_i && (slot_q.blk == blk_i)) slot_d.flag = 1'b0;
        if (set_i) begin
            slot_d.flag = 1'b1;
            slot_d.blk  = blk_i;
        end
        if (fail_i) begin
            slot_d.flag = 1'b0;
            slot_d.cnt  = slot_q.cnt + 1'b1;
            if (slot_q.ph == PH_W'(WARN_PERIOD - 1)) begin
                slot_d.ph = '0;
                fire_o    = 1'b1;
            end else begin
                slot_d.ph = slot_q.ph + 1'b1;
            end
        end
        if (clr_cnt_i) begin
            slot_d.cnt = '0;
            slot_d.ph  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign flag_o     = slot_q.flag;
    assign blk_o      = slot_q.blk;
    assign cnt_next_o = slot_d.cnt;

    a_r1_set_takes_block: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (flag_o && blk_o == $past(blk_i)));

    a_r4_fail_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fail_i |=> !flag_o);

    a_r6_snoop_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_i && !set_i && blk_o == blk_i) |=> !flag_o);

    a_r7_quiet_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !snoop_i && !fail_i) |=> $stable(flag_o));

    a_r8_fail_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && !clr_cnt_i) |=> slot_q.cnt == CNT_W'($past(slot_q.cnt) + 1'b1));

    a_r8_success_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt_i |=> slot_q.cnt == '0);

endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NCTX        = 4,
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000,
    parameter int BLK_LSB     = 4,
    parameter int CTX_W       = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_store,
    input  logic              req_locked,
    input  logic              req_uncached,
    output logic [1:0]        rsp_result,
    output logic              rsp_write_go,
    output logic              rsp_dest_we,
    output logic              warn_valid,
    output logic [CTX_W-1:0]  warn_ctx,
    output logic [CNT_W-1:0]  warn_count
);

    localparam int BLK_W = ADDR_W - BLK_LSB;

    typedef struct packed {
        logic             vld;
        logic [CTX_W-1:0] ctx;
        logic [CNT_W-1:0] cnt;
    } warn_t;

    rq_kind_e         kind;
    logic [BLK_W-1:0] req_blk;
    logic [NCTX-1:0]  flag_v;
    logic [NCTX-1:0]  fire_v;
    logic [BLK_W-1:0] blk_a  [NCTX];
    logic [CNT_W-1:0] cnt_a  [NCTX];
    logic             own_flag;
    logic [BLK_W-1:0] own_blk;
    logic             sc_ok;
    logic             sc_fail;
    logic             snoop;
    warn_t            warn_d, warn_q;

    assign req_blk = req_addr[ADDR_W-1:BLK_LSB];

    llsc_req_decode #(.NCTX(NCTX), .CTX_W(CTX_W)) u_decode (
        .valid_i    (req_valid),
        .ctx_i      (req_ctx),
        .store_i    (req_store),
        .locked_i   (req_locked),
        .uncached_i (req_uncached),
        .kind_o     (kind)
    );

    always_comb begin
        own_flag = 1'b0;
        own_blk  = '0;
        for (int i = 0; i < NCTX; i++) begin
            if (req_ctx == CTX_W'(i)) begin
                own_flag = flag_v[i];
                own_blk  = blk_a[i];
            end
        end
        sc_ok   = (kind == RQ_SC) && own_flag && (own_blk == req_blk);
        sc_fail = (kind == RQ_SC) && !sc_ok;
        snoop   = (kind == RQ_STORE) || (kind == RQ_SC_UC) || sc_ok;
    end

    for (genvar g = 0; g < NCTX; g++) begin : g_slot
        logic mine;
        assign mine = (req_ctx == CTX_W'(g));

        llsc_slot #(.BLK_W(BLK_W), .CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (mine && kind == RQ_LL),
            .blk_i      (req_blk),
            .snoop_i    (snoop),
            .fail_i     (mine && sc_fail),
            .clr_cnt_i  (mine && (sc_ok || kind == RQ_SC_UC)),
            .flag_o     (flag_v[g]),
            .blk_o      (blk_a[g]),
            .fire_o     (fire_v[g]),
            .cnt_next_o (cnt_a[g])
        );
    end

    always_comb begin
        rsp_result   = RES_FAIL;
        rsp_dest_we  = 1'b0;
        rsp_write_go = snoop;
        case (kind)
            RQ_SC: begin
                rsp_result  = {1'b0, own_flag};
                rsp_dest_we = 1'b1;
            end
            RQ_SC_UC: rsp_result = RES_UNCAC;
            default: ;
        endcase
    end

    always_comb begin
        warn_d = '0;
        for (int i = 0; i < NCTX; i++) begin
            if (fire_v[i]) begin
                warn_d.vld = 1'b1;
                warn_d.ctx = CTX_W'(i);
                warn_d.cnt = cnt_a[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) warn_q <= '0;
        else        warn_q <= warn_d;
    end

    assign warn_valid = warn_q.vld;
    assign warn_ctx   = warn_q.ctx;
    assign warn_count = warn_q.cnt;

    a_r9_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire_v));

    a_r9_warn_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        warn_valid |-> warn_count != '0);

    a_r3_grant_reports_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RQ_SC && rsp_write_go) |-> rsp_result == RES_OK);

    a_r7_load_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RQ_LOAD || kind == RQ_NONE) |-> (!rsp_write_go && !rsp_dest_we && rsp_result == RES_FAIL));

    a_r5_uncached_code: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RQ_SC_UC) |-> (rsp_result == RES_UNCAC && !rsp_dest_we));

endmodule

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;

    localparam int NCTX = 4;
    localparam int AW   = 16;
    localparam int CW   = 16;
    localparam int PER  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_ctx = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_store = 1'b0;
    logic          req_locked = 1'b0;
    logic          req_uncached = 1'b0;
    logic [1:0]    rsp_result;
    logic          rsp_write_go;
    logic          rsp_dest_we;
    logic          warn_valid;
    logic [1:0]    warn_ctx;
    logic [CW-1:0] warn_count;

    llsc_monitor #(.NCTX(NCTX), .ADDR_W(AW), .CNT_W(CW), .WARN_PERIOD(PER)) u_llsc_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
        .req_addr(req_addr), .req_store(req_store), .req_locked(req_locked),
        .req_uncached(req_uncached), .rsp_result(rsp_result),
        .rsp_write_go(rsp_write_go), .rsp_dest_we(rsp_dest_we),
        .warn_valid(warn_valid), .warn_ctx(warn_ctx), .warn_count(warn_count)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit        m_flag [NCTX];
    int        m_blk  [NCTX];
    int        m_cnt  [NCTX];
    bit        e_wv;
    int        e_wctx;
    int        e_wcnt;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NCTX; k++) begin
            m_flag[k] = 1'b0; m_blk[k] = 0; m_cnt[k] = 0;
        end
        e_wv = 1'b0;
    endtask

    task automatic check_warn();
        check(warn_valid == e_wv, "R9 warn_valid", int'(warn_valid), int'(e_wv));
        if (e_wv) begin
            check(int'(warn_ctx) == e_wctx, "R9 warn_ctx", int'(warn_ctx), e_wctx);
            check(int'(warn_count) == e_wcnt, "R8 warn_count", int'(warn_count), e_wcnt);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // drive one request at a falling edge, check outputs, update model
    task automatic req(input bit v, input int c, input int a, input bit st,
                       input bit lk, input bit uc, input string tag);
        int  b;
        int  e_res;
        bit  e_wgo, e_dwe, ok, snp;
        @(negedge clk);
        check_warn();
        req_valid = v; req_ctx = c[1:0]; req_addr = a[AW-1:0];
        req_store = st; req_locked = lk; req_uncached = uc;
        #2;
        b = a >> 4;
        e_res = 0; e_wgo = 0; e_dwe = 0; ok = 0; snp = 0;
        e_wv = 1'b0;
        if (v && c < NCTX) begin
            if (!st && lk) begin
                m_flag[c] = 1'b1; m_blk[c] = b;
            end else if (st && !lk) begin
                snp = 1'b1; e_wgo = 1'b1;
            end else if (st && lk && uc) begin
                e_res = 2; e_wgo = 1'b1; snp = 1'b1; m_cnt[c] = 0;
            end else if (st && lk) begin
                e_res = int'(m_flag[c]); e_dwe = 1'b1;
                ok = m_flag[c] && (m_blk[c] == b);
                e_wgo = ok; snp = ok;
                if (ok) m_cnt[c] = 0;
                else begin
                    m_flag[c] = 1'b0;
                    m_cnt[c]++;
                    if (m_cnt[c] % PER == 0) begin
                        e_wv = 1'b1; e_wctx = c; e_wcnt = m_cnt[c];
                    end
                end
            end
            if (snp)
                for (int k = 0; k < NCTX; k++)
                    if (m_blk[k] == b) m_flag[k] = 1'b0;
        end
        check(int'(rsp_result) == e_res, {tag, " result"}, int'(rsp_result), e_res);
        check(rsp_write_go == e_wgo, {tag, " write_go"}, int'(rsp_write_go), int'(e_wgo));
        check(rsp_dest_we == e_dwe, {tag, " dest_we"}, int'(rsp_dest_we), int'(e_dwe));
    endtask

    initial begin
        model_reset();
        do_reset();

        // R10: after reset no context holds a reservation and no warning
        for (int c = 0; c < NCTX; c++) req(1, c, 16'h0040, 1, 1, 0, "R10 post-reset SC");

        // R1 R2 R4 R6 R7: sweep owner, intruder, address offset and intruder op
        for (int a = 0; a < NCTX; a++)
            for (int b = 0; b < NCTX; b++)
                for (int o = 0; o < 4; o++)
                    for (int op = 0; op < 5; op++) begin
                        int off;
                        off = (o == 0) ? 0 : (o == 1) ? 4 : (o == 2) ? 15 : 16;
                        req(1, a, 16'h0120, 0, 1, 0, "R1 locked load");
                        case (op)
                            0: req(1, b, 16'h0120 + off, 0, 0, 0, "R7 plain load");
                            1: req(1, b, 16'h0120 + off, 1, 0, 0, "R6 plain store");
                            2: req(1, b, 16'h0120 + off, 1, 1, 0, "R4 other SC");
                            3: req(1, b, 16'h0120 + off, 1, 1, 1, "R5 uncached SC");
                            default: req(0, b, 16'h0120 + off, 1, 0, 0, "R7 idle");
                        endcase
                        req(1, a, 16'h0120 + (o == 2 ? 15 : 0), 1, 1, 0, "R2 R3 probe SC");
                    end

        // R8 R9: repeated failures then a success restarts the count
        for (int i = 0; i < 7; i++) req(1, 2, 16'h0200, 1, 1, 0, "R8 failing SC");
        req(1, 2, 16'h0200, 0, 1, 0, "R1 locked load");
        req(1, 2, 16'h0208, 1, 1, 0, "R3 success SC");
        for (int i = 0; i < 4; i++) req(1, 2, 16'h0200, 1, 1, 0, "R8 failing SC after reset of count");
        req(1, 1, 16'h0300, 1, 1, 0, "R8 other ctx SC");
        req(1, 1, 16'h0300, 1, 1, 1, "R8 uncached clears count");
        for (int i = 0; i < 3; i++) req(1, 1, 16'h0300, 1, 1, 0, "R9 warn after uncached");

        // R10: mid-run reset drops reservations and counts
        req(1, 3, 16'h0400, 0, 1, 0, "R1 locked load");
        req(1, 0, 16'h0500, 1, 1, 0, "R8 fail before reset");
        req(1, 0, 16'h0500, 1, 1, 0, "R8 fail before reset");
        req(0, 0, 0, 0, 0, 0, "R7 idle");
        do_reset();
        req(1, 3, 16'h0400, 1, 1, 0, "R10 reservation gone");
        for (int i = 0; i < 3; i++) req(1, 0, 16'h0500, 1, 1, 0, "R10 count restarted");

        // mixed stream over four blocks
        begin
            logic [31:0] s;
            s = 32'h1357_9bdf;
            for (int i = 0; i < 3000; i++) begin
                s = s * 32'd1103515245 + 32'd12345;
                req(s[30] | s[31], int'(s[17:16]), 16'h0100 + int'({s[21:20], 4'h0}) + int'(s[3:0]),
                    s[27], s[26], s[28] & s[29], "R3 R6 mixed");
            end
        end
        req(0, 0, 0, 0, 0, 0, "R7 idle");
        @(negedge clk);
        check_warn();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule